// File: doc/BRIEF.md
# Pipeline Drain Coordinator

This block runs the quiesce handshake of a five-stage processor pipeline. The stages are fetch (index 0), decode (1), rename (2), issue/execute/writeback (3) and commit (4). When software or a mode controller asks for a drain, the block wakes the pipeline if it was idle and sends every stage a one-cycle drain notification. It then collects one acknowledgement per stage. When all five have been counted, it stops the pipeline tick-enable, reports the Drained status and pulses a done flag. A later resume command returns the pipeline to Running. A switch-out command parks the pipeline for good until reset and pulses a clear of the in-flight instruction tracking.

The stages do not all acknowledge under the same condition. Decode, rename and issue/execute acknowledge in the same cycle as their notification. Fetch also acknowledges at once, but from the drain request onward it holds off new cache-line requests and discards returning instruction-cache data, until a resume arrives. Commit keeps a pending flag and acknowledges only in a cycle where the reorder buffer is empty and no store waits for writeback. Acknowledgements are one-cycle pulses, and several may land in one cycle; the counter adds them all and saturates at the stage count.

The control state machine has five states: RUN, IDLE, DRAINING, DRAINED and SWOUT. The transitions are:
- SWOUT is entered from any state on a switch command.
- RUN is entered from any state other than SWOUT on a resume.
- DRAINING is entered from any state other than SWOUT on a drain request.
- RUN goes to IDLE while the idle request is high, and IDLE goes back to RUN when it drops.
- DRAINING goes to DRAINED once all acknowledgements are in.

Top module: `pqc_drain_ctrl`

## Requirements
- R1: After reset the status is Running, the tick-enable is 1, and the fetch hold, the stage notifications, the done pulse and the in-flight clear are all 0.
- R2: A drain request accepted at a clock edge makes all five stage notifications high for exactly the following cycle. The same edge sets the fetch hold. The status becomes Running with the tick-enable at 1, also when the pipeline was Idle.
- R3: Stages 0 to 3 acknowledge together with their notification. Commit (stage 4) acknowledges in the first cycle, from its notification onward, in which the reorder buffer is empty and stores-pending is 0.
- R4: The edge at which the fifth acknowledgement is counted moves the status to Drained and the tick-enable to 0. It also raises the done pulse for exactly one cycle. With commit ready at once, the done pulse follows the stage notifications directly.
- R5: The acknowledgement count never exceeds five, and one drain produces exactly one done pulse.
- R6: While the fetch hold is high, an instruction-cache response is dropped: the keep output is 0. Otherwise the keep output follows the response-valid input.
- R7: A resume outside SwitchedOut sets the status to Running, the tick-enable to 1 and the fetch hold to 0. It also abandons a drain in progress, so no done pulse follows.
- R8: A switch command sets the status to SwitchedOut, the tick-enable to 0 and the fetch hold to 1, and pulses the in-flight clear for one cycle.
- R9: In SwitchedOut, resume and drain requests have no effect: the status stays SwitchedOut, no notification is sent and the hold stays high.
- R10: In Running, an idle request moves the status to Idle with the tick-enable at 0. Removing the request returns the status to Running.
- R11: The status is a 3-bit code: Running 0, Idle 1, Halted 2, Blocked 3, Drained 4, SwitchedOut 5.
- R12: When commands coincide, switch wins over resume, and resume wins over drain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drain_req | input | 1 | One-cycle drain request |
| resume_cmd | input | 1 | One-cycle resume command |
| switch_cmd | input | 1 | One-cycle switch-out command |
| idle_req | input | 1 | Pipeline has no work (level) |
| rob_empty | input | 1 | Reorder buffer is empty |
| stores_pending | input | 1 | Stores still await writeback |
| icache_resp_valid | input | 1 | Instruction-cache response arriving |
| stage_drain | output | NSTAGE | Per-stage drain notification pulse |
| fetch_hold | output | 1 | Fetch must issue no new line requests |
| icache_resp_keep | output | 1 | Response may be used by fetch |
| tick_en | output | 1 | Pipeline clock-enable |
| status | output | 3 | Status code (R11) |
| drain_done | output | 1 | One-cycle drain-complete pulse |
| inflight_clear | output | 1 | One-cycle clear of in-flight lists |

## Verification
The assertions check the following on every cycle:
- the count ceiling;
- that a done pulse coincides with Drained status and a stopped tick;
- that the hold and the discard of cache responses agree;
- the effect of each accepted command one cycle later;
- the stickiness of SwitchedOut.

Commit's wait on the reorder buffer and on pending stores can only be shown by the bench's scenarios. The same holds for a resume that abandons a drain and for the exact cycle of the done pulse. Those scenarios are compared against a reference model at every clock.

// File: rtl/pqc_pkg.sv
package pqc_pkg;
    typedef enum logic [2:0] {
        ST_RUNNING  = 3'd0,
        ST_IDLE     = 3'd1,
        ST_HALTED   = 3'd2,
        ST_BLOCKED  = 3'd3,
        ST_DRAINED  = 3'd4,
        ST_SWITCHED = 3'd5
    } pipe_status_e;

    typedef enum logic [2:0] {
        C_RUN,
        C_IDLE,
        C_DRAINING,
        C_DRAINED,
        C_SWOUT
    } ctrl_state_e;
endpackage

// File: rtl/pqc_ack_agents.sv
module pqc_ack_agents #(
    parameter int NSTAGE     = 5,
    parameter int COMMIT_IDX = NSTAGE - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSTAGE-1:0] notify,
    input  logic              abort,
    input  logic              rob_empty,
    input  logic              stores_pending,
    output logic [NSTAGE-1:0] ack
);
    for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
        if (g == COMMIT_IDX) begin : g_commit
            logic pend_q;
            logic waiting;
            assign waiting = notify[g] | pend_q;
            assign ack[g]  = waiting & rob_empty & ~stores_pending;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    pend_q <= 1'b0;
                else if (abort)
                    pend_q <= 1'b0;
                else
                    pend_q <= waiting & ~ack[g];
            end
        end else begin : g_fast
            assign ack[g] = notify[g];
        end
    end
endmodule

// File: rtl/pqc_ack_count.sv
module pqc_ack_count #(
    parameter int NSTAGE = 5,
    localparam int CW    = $clog2(NSTAGE + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              en,
    input  logic [NSTAGE-1:0] acks,
    output logic [CW-1:0]     count,
    output logic [CW-1:0]     sum
);
    logic [CW-1:0] count_q;
    int            total;

    always_comb begin
        total = int'(count_q);
        for (int i = 0; i < NSTAGE; i++)
            total = total + int'(acks[i]);
        if (total > NSTAGE)
            total = NSTAGE;
        sum = CW'(total);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count_q <= '0;
        else if (clear)
            count_q <= '0;
        else if (en)
            count_q <= sum;
    end

    assign count = count_q;
endmodule

// File: rtl/pqc_drain_ctrl.sv
module pqc_drain_ctrl
    import pqc_pkg::*;
#(
    parameter int NSTAGE     = 5,
    parameter int COMMIT_IDX = NSTAGE - 1,
    localparam int CW        = $clog2(NSTAGE + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              drain_req,
    input  logic              resume_cmd,
    input  logic              switch_cmd,
    input  logic              idle_req,
    input  logic              rob_empty,
    input  logic              stores_pending,
    input  logic              icache_resp_valid,
    output logic [NSTAGE-1:0] stage_drain,
    output logic              fetch_hold,
    output logic              icache_resp_keep,
    output logic              tick_en,
    output logic [2:0]        status,
    output logic              drain_done,
    output logic              inflight_clear
);
    ctrl_state_e       state_q, state_d;
    logic              switch_go, resume_go, drain_go, all_acked;
    logic [NSTAGE-1:0] acks;
    logic [CW-1:0]     ack_cnt, ack_sum;

    // command priority: switch > resume > drain (R12)
    assign switch_go = switch_cmd;
    assign resume_go = resume_cmd && (state_q != C_SWOUT) && !switch_cmd;
    assign drain_go  = drain_req && (state_q != C_SWOUT) && !switch_cmd && !resume_go;
    assign all_acked = (state_q == C_DRAINING) && !switch_go && !resume_go
                       && !drain_go && (ack_sum == CW'(NSTAGE));

    pqc_ack_agents #(.NSTAGE(NSTAGE), .COMMIT_IDX(COMMIT_IDX)) u_agents (
        .clk            (clk),
        .rst_n          (rst_n),
        .notify         (stage_drain),
        .abort          (switch_go | resume_go | drain_go),
        .rob_empty      (rob_empty),
        .stores_pending (stores_pending),
        .ack            (acks)
    );

    pqc_ack_count #(.NSTAGE(NSTAGE)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (drain_go),
        .en    (state_q == C_DRAINING),
        .acks  (acks),
        .count (ack_cnt),
        .sum   (ack_sum)
    );

    always_comb begin
        state_d = state_q;
        if (switch_go)
            state_d = C_SWOUT;
        else if (resume_go)
            state_d = C_RUN;
        else if (drain_go)
            state_d = C_DRAINING;
        else begin
            unique case (state_q)
                C_RUN:      if (idle_req)  state_d = C_IDLE;
                C_IDLE:     if (!idle_req) state_d = C_RUN;
                C_DRAINING: if (all_acked) state_d = C_DRAINED;
                C_DRAINED:  state_d = C_DRAINED;
                C_SWOUT:    state_d = C_SWOUT;
                default:    state_d = C_RUN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= C_RUN;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_drain    <= '0;
            drain_done     <= 1'b0;
            inflight_clear <= 1'b0;
            fetch_hold     <= 1'b0;
        end else begin
            stage_drain    <= {NSTAGE{drain_go}};
            drain_done     <= all_acked;
            inflight_clear <= switch_go;
            if (switch_go)
                fetch_hold <= 1'b1;
            else if (resume_go)
                fetch_hold <= 1'b0;
            else if (drain_go)
                fetch_hold <= 1'b1;
        end
    end

    always_comb begin
        unique case (state_q)
            C_RUN:      begin status = ST_RUNNING;  tick_en = 1'b1; end
            C_IDLE:     begin status = ST_IDLE;     tick_en = 1'b0; end
            C_DRAINING: begin status = ST_RUNNING;  tick_en = 1'b1; end
            C_DRAINED:  begin status = ST_DRAINED;  tick_en = 1'b0; end
            C_SWOUT:    begin status = ST_SWITCHED; tick_en = 1'b0; end
            default:    begin status = ST_RUNNING;  tick_en = 1'b1; end
        endcase
    end

    assign icache_resp_keep = icache_resp_valid & ~fetch_hold;
endmodule

// File: rtl/pqc_drain_checker.sv
module pqc_drain_checker #(
    parameter int NSTAGE = 5,
    localparam int CW    = $clog2(NSTAGE + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              drain_req,
    input logic              resume_cmd,
    input logic              switch_cmd,
    input logic              icache_resp_keep,
    input logic [NSTAGE-1:0] stage_drain,
    input logic              fetch_hold,
    input logic              tick_en,
    input logic [2:0]        status,
    input logic              drain_done,
    input logic              inflight_clear,
    input logic [CW-1:0]     ack_cnt
);
    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        ack_cnt <= CW'(NSTAGE)); // R5
    AST_DONE_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
        drain_done |-> (status == 3'd4) && !tick_en); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        drain_done |=> !drain_done); // R4
    AST_HOLD_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_hold |-> !icache_resp_keep); // R6
    AST_NOTIFY_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_drain != '0) |-> (&stage_drain) && fetch_hold && tick_en); // R2
    AST_DRAIN_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_req && status != 3'd5 && !switch_cmd && !resume_cmd)
        |=> (&stage_drain) && (status == 3'd0)); // R2
    AST_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
        (resume_cmd && status != 3'd5 && !switch_cmd)
        |=> (status == 3'd0) && tick_en && !fetch_hold); // R7
    AST_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
        switch_cmd |=> (status == 3'd5) && inflight_clear && fetch_hold && !tick_en); // R8
    AST_SW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 3'd5) |=> (status == 3'd5) && (stage_drain == '0)); // R9
endmodule

bind pqc_drain_ctrl pqc_drain_checker #(.NSTAGE(NSTAGE)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .drain_req        (drain_req),
    .resume_cmd       (resume_cmd),
    .switch_cmd       (switch_cmd),
    .icache_resp_keep (icache_resp_keep),
    .stage_drain      (stage_drain),
    .fetch_hold       (fetch_hold),
    .tick_en          (tick_en),
    .status           (status),
    .drain_done       (drain_done),
    .inflight_clear   (inflight_clear),
    .ack_cnt          (ack_cnt)
);

// File: tb/pqc_drain_ctrl_bench.sv
`timescale 1ns/1ps
module pqc_drain_ctrl_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic drain_req = 0, resume_cmd = 0, switch_cmd = 0, idle_req = 0;
    logic rob_empty = 1, stores_pending = 0, icache_resp_valid = 0;
    logic [4:0] stage_drain;
    logic fetch_hold, icache_resp_keep, tick_en, drain_done, inflight_clear;
    logic [2:0] status;

    always #2.5 clk = ~clk;

    pqc_drain_ctrl u_pqc_drain_ctrl (
        .clk(clk), .rst_n(rst_n), .drain_req(drain_req), .resume_cmd(resume_cmd),
        .switch_cmd(switch_cmd), .idle_req(idle_req), .rob_empty(rob_empty),
        .stores_pending(stores_pending), .icache_resp_valid(icache_resp_valid),
        .stage_drain(stage_drain), .fetch_hold(fetch_hold),
        .icache_resp_keep(icache_resp_keep), .tick_en(tick_en), .status(status),
        .drain_done(drain_done), .inflight_clear(inflight_clear)
    );

    int checks = 0;
    int fails = 0;
    int dones = 0;
    string cur_req = "R1";

    // reference model: 0 run, 1 idle, 2 draining, 3 drained, 4 switched out
    int m_st = 0, m_cnt = 0;
    bit m_notify = 0, m_wait = 0, m_done = 0, m_clear = 0, m_hold = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_notify = 0; m_wait = 0;
            m_done = 0; m_clear = 0; m_hold = 0;
        end else begin
            bit rs, dg, cok, fin;
            int tot;
            rs  = resume_cmd && m_st != 4 && !switch_cmd;
            dg  = drain_req && m_st != 4 && !switch_cmd && !rs;
            cok = (m_notify || m_wait) && rob_empty && !stores_pending;
            tot = m_cnt + (m_notify ? 4 : 0) + (cok ? 1 : 0);
            if (tot > 5) tot = 5;
            fin = (m_st == 2) && !switch_cmd && !rs && !dg && tot == 5;
            m_wait = !(switch_cmd || rs || dg) && (m_notify || m_wait) && !cok;
            if (dg) m_cnt = 0;
            else if (m_st == 2) m_cnt = tot;
            if (switch_cmd) m_hold = 1;
            else if (rs) m_hold = 0;
            else if (dg) m_hold = 1;
            m_notify = dg;
            m_done = fin;
            m_clear = switch_cmd;
            if (switch_cmd) m_st = 4;
            else if (rs) m_st = 0;
            else if (dg) m_st = 2;
            else if (m_st == 0 && idle_req) m_st = 1;
            else if (m_st == 1 && !idle_req) m_st = 0;
            else if (fin) m_st = 3;
        end
    end

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
        end
    endtask

    task automatic compare();
        int es;
        es = (m_st == 1) ? 1 : (m_st == 3) ? 4 : (m_st == 4) ? 5 : 0;
        chk("status", status, es);
        chk("tick_en", tick_en, (m_st == 0 || m_st == 2) ? 1 : 0);
        chk("stage_drain", stage_drain, m_notify ? 31 : 0);
        chk("fetch_hold", fetch_hold, m_hold);
        chk("drain_done", drain_done, m_done);
        chk("inflight_clear", inflight_clear, m_clear);
        chk("icache_resp_keep", icache_resp_keep, icache_resp_valid && !m_hold);
        if (drain_done) dones++;
    endtask

    task automatic cyc(input bit d, input bit r, input bit s, input bit idl,
                       input bit rob, input bit st, input bit icv);
        drain_req = d; resume_cmd = r; switch_cmd = s; idle_req = idl;
        rob_empty = rob; stores_pending = st; icache_resp_valid = icv;
        @(negedge clk);
        compare();
    endtask

    task automatic quiet(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 1, 0, 0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R1";
        chk("reset status", status, 0);
        chk("reset tick", tick_en, 1);
        rst_n = 1'b1;
        @(negedge clk);
        compare();

        // R2 R3 R4: immediate drain, all ready
        cur_req = "R4";
        cyc(1, 0, 0, 0, 1, 0, 0);
        chk("R2 notify after request", stage_drain, 31);
        cyc(0, 0, 0, 0, 1, 0, 0);
        chk("R4 done next cycle", drain_done, 1);
        chk("R11 drained code", status, 4);
        quiet(2);

        // R6/R7: discard while held, then resume
        cur_req = "R6";
        cyc(0, 0, 0, 0, 1, 0, 1);
        chk("R6 discard", icache_resp_keep, 0);
        cur_req = "R7";
        cyc(0, 1, 0, 0, 1, 0, 1);
        chk("R7 keep after resume", icache_resp_keep, 1);
        quiet(1);

        // R3: commit waits for empty rob and no stores
        cur_req = "R3";
        dones = 0;
        cyc(1, 0, 0, 0, 0, 1, 0);
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, 1, 0);
        cyc(0, 0, 0, 0, 1, 1, 0);
        cyc(0, 0, 0, 0, 0, 0, 0);
        chk("R3 no done before ready", dones, 0);
        cyc(0, 0, 0, 0, 1, 0, 0);
        cur_req = "R5";
        quiet(4);
        chk("R5 exactly one done", dones, 1);
        cyc(0, 1, 0, 0, 1, 0, 0);

        // R10 idle, R2 wake from idle
        cur_req = "R10";
        cyc(0, 0, 0, 1, 1, 0, 0);
        cyc(0, 0, 0, 1, 1, 0, 0);
        chk("R10 idle tick", tick_en, 0);
        cyc(0, 0, 0, 0, 1, 0, 0);
        cyc(0, 0, 0, 1, 1, 0, 0);
        cur_req = "R2";
        cyc(1, 0, 0, 1, 0, 0, 0);
        chk("R2 wake tick", tick_en, 1);
        cyc(0, 0, 0, 1, 0, 0, 0);

        // R7: resume abandons drain
        cur_req = "R7";
        dones = 0;
        cyc(0, 1, 0, 0, 0, 0, 0);
        quiet(4);
        chk("R7 no done after abort", dones, 0);

        // R12: coincident commands
        cur_req = "R12";
        cyc(1, 1, 0, 0, 1, 0, 0);
        chk("R12 resume beats drain", stage_drain, 0);
        cyc(1, 1, 1, 0, 1, 0, 0);
        chk("R12 switch wins", status, 5);

        // R8/R9: switched out is sticky
        cur_req = "R8";
        chk("R8 clear pulse", inflight_clear, 1);
        quiet(1);
        cur_req = "R9";
        cyc(0, 1, 0, 0, 1, 0, 1);
        cyc(1, 0, 0, 0, 1, 0, 1);
        cyc(0, 0, 0, 0, 1, 0, 0);
        chk("R9 stays switched", status, 5);
        chk("R9 no notify", stage_drain, 0);
        quiet(2);
        finish_run();
    end
endmodule